// File: doc/BRIEF.md
# Virtual Function Command and Status Register

This block holds the 32-bit combined command and status word of one virtual function in a PCI Express endpoint. A local management bus reads and writes it. The transaction layer reports error events to it as single-cycle pulses. The only writable command field is the bus-master enable. The capabilities-present flag is fixed at one. Every other command bit and every reserved bit reads as zero.

Six status flags record error events: data parity, completer abort sent, completer abort received, unsupported request received, system error signalled, and parity error detected. Each flag stays set until software writes one to its bit, or until a power-on reset. Two of these flags are qualified by enables that come from the parent physical function. A function-level reset returns the bus-master enable to zero and leaves the error flags untouched. A read returns the whole word one clock after the request.

Top module: `vf_cmd_status_reg`

## Requirements
- R1: After a power-on reset the register reads 0x0010_0000, and `mgmt_rd_valid` is 0 until the first read.
- R2: Bit 2 (bus-master enable) takes `mgmt_wdata[2]` on a write with `mgmt_be[0]` high and reads back that value.
- R3: Bit 20 always reads 1. Bits 0-1, 3-19 and 21-23 always read 0, and writes do not change them.
- R4: A write changes only the bytes whose `mgmt_be` bit is 1. `mgmt_be[0]` covers bits 7:0 and `mgmt_be[3]` covers bits 31:24.
- R5: Bit 24 is set by `ev_poison_cpl_rx` or `ev_poison_wr_tx` only while `pf_parity_resp_en` is 1. Otherwise these events leave it unchanged.
- R6: `ev_ca_cpl_tx` sets bit 27, `ev_ca_cpl_rx` sets bit 28 and `ev_ur_cpl_rx` sets bit 29, whatever the state of the enables.
- R7: `ev_err_msg_tx` sets bit 30 only while `pf_serr_en` is 1. Otherwise bit 30 stays as it was.
- R8: `ev_poison_tlp_rx` sets bit 31 whatever the value of `pf_parity_resp_en`.
- R9: Bits 24 and 27-31 hold once set. Writing 1 to one of them, with `mgmt_be[3]` high, clears it. Writing 0 leaves it unchanged.
- R10: If an event and a clearing write hit the same status bit in the same cycle, the bit ends at 1.
- R11: A low `flr_rst_n` clears bus-master enable and keeps every status bit.
- R12: A read request in one cycle gives `mgmt_rd_valid` high with the full word on `mgmt_rdata` in the next cycle. That word is the register value before the edge at which the request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| flr_rst_n | input | 1 | Function-level reset, synchronous, active low; clears the command bit only |
| mgmt_wr_en | input | 1 | Management write strobe |
| mgmt_rd_en | input | 1 | Management read strobe |
| mgmt_wdata | input | 32 | Write data |
| mgmt_be | input | 4 | Byte enables for the write |
| mgmt_rdata | output | 32 | Read data, registered |
| mgmt_rd_valid | output | 1 | Read data valid, one cycle after `mgmt_rd_en` |
| pf_parity_resp_en | input | 1 | Parity error response enable from the physical function |
| pf_serr_en | input | 1 | System error enable from the physical function |
| ev_poison_cpl_rx | input | 1 | Pulse: poisoned completion received for this function's request |
| ev_poison_wr_tx | input | 1 | Pulse: poisoned write request sent by this function |
| ev_ca_cpl_tx | input | 1 | Pulse: completion with Completer Abort sent |
| ev_ca_cpl_rx | input | 1 | Pulse: completion with Completer Abort received |
| ev_ur_cpl_rx | input | 1 | Pulse: completion with Unsupported Request received |
| ev_err_msg_tx | input | 1 | Pulse: fatal or non-fatal error message sent |
| ev_poison_tlp_rx | input | 1 | Pulse: poisoned TLP targeting this function received |

## Verification
On every cycle the assertions check the following:
- each status flag sets after its qualified event and holds unless cleared;
- a lone clear drops the flag;
- the two gated flags cannot rise while their enable is off;
- the function-level reset drops bus-master enable;
- every returned word has bit 20 set and all reserved bits zero.

Some behaviour shows only in the bench scenarios:
- the exact effect of each byte-enable pattern on a write;
- the mapping from each event and enable combination to a bit position;
- the outcome when a set and a clear hit the same bit in one cycle;
- that a function-level reset keeps the status flags.

// File: rtl/vf_csr_pkg.sv
// Package: shared bit positions and event bundle for the virtual-function
// command/status register. Assumes a 32-bit register word.
package vf_csr_pkg;

    localparam int unsigned NUM_STICKY = 6;
    localparam int unsigned BME_POS    = 2;
    localparam int unsigned CAPL_POS   = 20;

    // Status flag index -> bit position in the register word.
    // 0 data parity, 1 abort sent, 2 abort received, 3 unsupported received,
    // 4 system error signalled, 5 parity detected
    localparam int unsigned STICKY_POS [NUM_STICKY] = '{24, 27, 28, 29, 30, 31};

    // Raw event pulses from the transaction layer
    typedef struct packed {
        logic poison_cpl_rx;
        logic poison_wr_tx;
        logic ca_cpl_tx;
        logic ca_cpl_rx;
        logic ur_cpl_rx;
        logic err_msg_tx;
        logic poison_tlp_rx;
    } vf_evt_t;

endpackage

// File: rtl/vf_csr_cmd.sv
// Module: bus-master enable command bit.
// Assumes synchronous active-low resets; the power-on and the function-level
// reset both clear the bit, and either reset wins over a write.
module vf_csr_cmd (
    input  logic clk,
    input  logic por_rst_n,
    input  logic flr_rst_n,
    input  logic wr_byte0,
    input  logic wr_bit,
    output logic bme_q
);

    // Register the bus-master enable.
    always_ff @(posedge clk) begin
        if (!por_rst_n || !flr_rst_n) begin
            bme_q <= 1'b0;
        end else if (wr_byte0) begin
            bme_q <= wr_bit;
        end
    end

    // R11: a function-level reset leaves bus-master enable at 0
    assert_flr_clears_bme_R11: assert property (@(posedge clk) disable iff (!por_rst_n)
        !flr_rst_n |=> !bme_q);

    // R2: a write with the low byte enabled takes effect
    assert_bme_write_R2: assert property (@(posedge clk) disable iff (!por_rst_n)
        (flr_rst_n && wr_byte0) |=> (bme_q == $past(wr_bit)));

endmodule

// File: rtl/vf_csr_event_map.sv
// Module: qualifies raw transaction-layer events with the physical
// function's enables and maps them to status flag set requests.
// Assumes events are single-cycle pulses; the output is purely combinational.
module vf_csr_event_map
    import vf_csr_pkg::*;
(
    input  vf_evt_t                 evt,
    input  logic                    parity_resp_en,
    input  logic                    serr_en,
    output logic [NUM_STICKY-1:0]   set_req
);

    // Combine events into per-flag set requests.
    always_comb begin
        set_req    = '0;
        set_req[0] = parity_resp_en && (evt.poison_cpl_rx || evt.poison_wr_tx);
        set_req[1] = evt.ca_cpl_tx;
        set_req[2] = evt.ca_cpl_rx;
        set_req[3] = evt.ur_cpl_rx;
        set_req[4] = serr_en && evt.err_msg_tx;
        set_req[5] = evt.poison_tlp_rx;
    end

endmodule

// File: rtl/vf_csr_sticky.sv
// Module: an array of sticky, write-one-to-clear status flags.
// Assumes a synchronous active-low power-on reset is the only reset that
// clears the flags; a set request wins over a clear in the same cycle.
module vf_csr_sticky #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         por_rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one sticky flag.
        always_ff @(posedge clk) begin
            if (!por_rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_req[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_req[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        // R10: a set request wins, even with a clear in the same cycle
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!por_rst_n)
            set_req[i] |=> flag_q[i]);

        // R9: a set flag holds without a clear
        assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
            (flag_q[i] && !clr_req[i]) |=> flag_q[i]);

        // R9: a lone clear drops the flag
        assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
            (clr_req[i] && !set_req[i]) |=> !flag_q[i]);
    end

endmodule

// File: rtl/vf_csr_rdport.sv
// Module: registered read port; captures the assembled register image
// on a read request and presents it one cycle later with a valid flag.
// Assumes synchronous active-low power-on reset.
module vf_csr_rdport #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] image,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);

    localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'(32'hF910_0004);

    // Capture read data and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!por_rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rdata <= image;
            end
        end
    end

    // R12: valid follows a request by exactly one cycle
    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!por_rst_n)
        rd_en |=> rd_valid);

    // R3: returned words have the capability flag set and reserved bits clear
    assert_const_bits_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
        rd_valid |-> (rdata[20] && ((rdata & ~LIVE_MASK) == '0)));

endmodule

// File: rtl/vf_cmd_status_reg.sv
// Module: command/status register of one virtual function.
// Decodes management writes per byte, routes event pulses into sticky
// status flags, holds bus-master enable and assembles the read image.
// Assumes a single-register address space, so no address decoding.
module vf_cmd_status_reg
    import vf_csr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_rst_n,
    input  logic              flr_rst_n,
    input  logic              mgmt_wr_en,
    input  logic              mgmt_rd_en,
    input  logic [DATA_W-1:0] mgmt_wdata,
    input  logic [DATA_W/8-1:0] mgmt_be,
    output logic [DATA_W-1:0] mgmt_rdata,
    output logic              mgmt_rd_valid,
    input  logic              pf_parity_resp_en,
    input  logic              pf_serr_en,
    input  logic              ev_poison_cpl_rx,
    input  logic              ev_poison_wr_tx,
    input  logic              ev_ca_cpl_tx,
    input  logic              ev_ca_cpl_rx,
    input  logic              ev_ur_cpl_rx,
    input  logic              ev_err_msg_tx,
    input  logic              ev_poison_tlp_rx
);

    localparam int unsigned BE_W = DATA_W / 8;

    vf_evt_t               evt;
    logic [NUM_STICKY-1:0] set_req;
    logic [NUM_STICKY-1:0] clr_req;
    logic [NUM_STICKY-1:0] flag_q;
    logic                  bme_q;
    logic [DATA_W-1:0]     image;
    logic                  unused_wdata;

    assign unused_wdata = ^{mgmt_wdata, mgmt_be[BE_W-1:0]};

    // Bundle the event pulses.
    always_comb begin
        evt.poison_cpl_rx = ev_poison_cpl_rx;
        evt.poison_wr_tx  = ev_poison_wr_tx;
        evt.ca_cpl_tx     = ev_ca_cpl_tx;
        evt.ca_cpl_rx     = ev_ca_cpl_rx;
        evt.ur_cpl_rx     = ev_ur_cpl_rx;
        evt.err_msg_tx    = ev_err_msg_tx;
        evt.poison_tlp_rx = ev_poison_tlp_rx;
    end

    // Per-flag clear decode: write strobe, owning byte enable, data bit.
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_clr
        assign clr_req[i] = mgmt_wr_en && mgmt_be[STICKY_POS[i] / 8]
                            && mgmt_wdata[STICKY_POS[i]];
    end

    vf_csr_event_map u_evmap (
        .evt            (evt),
        .parity_resp_en (pf_parity_resp_en),
        .serr_en        (pf_serr_en),
        .set_req        (set_req)
    );

    vf_csr_sticky #(.N(NUM_STICKY)) u_sticky (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .flag_q    (flag_q)
    );

    vf_csr_cmd u_cmd (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .flr_rst_n (flr_rst_n),
        .wr_byte0  (mgmt_wr_en && mgmt_be[BME_POS / 8]),
        .wr_bit    (mgmt_wdata[BME_POS]),
        .bme_q     (bme_q)
    );

    // Assemble the read image from live state and constants.
    always_comb begin
        image           = '0;
        image[CAPL_POS] = 1'b1;
        image[BME_POS]  = bme_q;
        for (int i = 0; i < NUM_STICKY; i++) begin
            image[STICKY_POS[i]] = flag_q[i];
        end
    end

    vf_csr_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .rd_en     (mgmt_rd_en),
        .image     (image),
        .rdata     (mgmt_rdata),
        .rd_valid  (mgmt_rd_valid)
    );

    // R5: data parity flag cannot rise while parity response is off
    assert_parity_gate_R5: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!pf_parity_resp_en && !flag_q[0]) |=> !flag_q[0]);

    // R7: system error flag cannot rise while SERR enable is off
    assert_serr_gate_R7: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!pf_serr_en && !flag_q[4]) |=> !flag_q[4]);

    // R8: a poisoned TLP always sets the detected flag
    assert_detect_ungated_R8: assert property (@(posedge clk) disable iff (!por_rst_n)
        ev_poison_tlp_rx |=> flag_q[5]);

    // R11: a function-level reset keeps status flags unless explicitly cleared
    assert_flr_keeps_flags_R11: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!flr_rst_n && !mgmt_wr_en) |=> (flag_q == ($past(flag_q) | $past(set_req))));

endmodule

// File: tb/vf_cmd_status_reg_tb.sv
// Bench: sweeps byte enables, write data, events and enable combinations,
// predicting the register word arithmetically.
module vf_cmd_status_reg_tb;

    logic        clk = 1'b0;
    logic        por_rst_n, flr_rst_n;
    logic        wr_en, rd_en;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        pe, se;
    logic [6:0]  ev;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_st;
    logic        m_bme;

    localparam logic [31:0] ST_MASK = 32'hF900_0000;

    always #2 clk = ~clk;

    vf_cmd_status_reg u_dut (
        .clk               (clk),
        .por_rst_n         (por_rst_n),
        .flr_rst_n         (flr_rst_n),
        .mgmt_wr_en        (wr_en),
        .mgmt_rd_en        (rd_en),
        .mgmt_wdata        (wdata),
        .mgmt_be           (be),
        .mgmt_rdata        (rdata),
        .mgmt_rd_valid     (rd_valid),
        .pf_parity_resp_en (pe),
        .pf_serr_en        (se),
        .ev_poison_cpl_rx  (ev[0]),
        .ev_poison_wr_tx   (ev[1]),
        .ev_ca_cpl_tx      (ev[2]),
        .ev_ca_cpl_rx      (ev[3]),
        .ev_ur_cpl_rx      (ev[4]),
        .ev_err_msg_tx     (ev[5]),
        .ev_poison_tlp_rx  (ev[6])
    );

    function automatic logic [31:0] sets_of(logic [6:0] e, logic p, logic s);
        logic [31:0] r = '0;
        if (p && (e[0] || e[1])) r[24] = 1'b1;
        if (e[2]) r[27] = 1'b1;
        if (e[3]) r[28] = 1'b1;
        if (e[4]) r[29] = 1'b1;
        if (s && e[5]) r[30] = 1'b1;
        if (e[6]) r[31] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] expect_word();
        return m_st | 32'h0010_0000 | {29'd0, m_bme, 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One cycle combining a write and events; updates the model.
    task automatic cycle(input bit w, input logic [31:0] d, input logic [3:0] b,
                         input logic [6:0] e, input logic p, input logic s);
        @(negedge clk);
        wr_en = w; wdata = d; be = b; ev = e; pe = p; se = s;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        if (w && b[0]) m_bme = d[2];
        if (w && b[3]) m_st = m_st & ~(d & ST_MASK);
        m_st = m_st | sets_of(e, p, s);
    endtask

    task automatic read_check(input string req);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, "R12", {31'd0, rd_valid}, 32'd1);
        check(rdata === expect_word(), req, rdata, expect_word());
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        por_rst_n = 1'b0; flr_rst_n = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0; be = '0;
        pe = 1'b0; se = 1'b0; ev = '0;
        m_st = '0; m_bme = 1'b0;
        repeat (3) @(negedge clk);
        por_rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, valid low before any read
        check(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
        read_check("R1");
        check(rdata === 32'h0010_0000, "R1", rdata, 32'h0010_0000);
        @(negedge clk);
        check(rd_valid === 1'b0, "R12", {31'd0, rd_valid}, 32'd0);

        // R2 R3 R4 R9: sweep every byte-enable pattern with all-ones and all-zeros
        for (int b = 0; b < 16; b++) begin
            for (int k = 0; k < 2; k++) begin
                cycle(1'b0, '0, '0, 7'h7F, 1'b1, 1'b1);
                cycle(1'b1, (k == 0) ? 32'hFFFF_FFFF : 32'h0000_0000, b[3:0], '0, 1'b0, 1'b0);
                read_check("R4");
            end
        end

        // R5 R6 R7 R8: every single event under every enable combination
        for (int e = 0; e < 7; e++) begin
            for (int en = 0; en < 4; en++) begin
                cycle(1'b1, 32'hFFFF_FFFF, 4'hF, '0, 1'b0, 1'b0);
                cycle(1'b0, '0, '0, 7'(1 << e), en[0], en[1]);
                read_check((e < 2) ? "R5" : (e == 5) ? "R7" : (e == 6) ? "R8" : "R6");
            end
        end

        // R9: writing zeros with all bytes enabled leaves flags set
        cycle(1'b0, '0, '0, 7'h7F, 1'b1, 1'b1);
        cycle(1'b1, 32'h0000_0000, 4'hF, '0, 1'b0, 1'b0);
        read_check("R9");
        check(rdata[31:24] === 8'hF9, "R9", {24'd0, rdata[31:24]}, 32'hF9);

        // R10: set and clear in the same cycle, flags stay set
        cycle(1'b1, 32'hFFFF_FFFF, 4'hF, '0, 1'b0, 1'b0);
        cycle(1'b1, 32'hFFFF_FFFF, 4'hF, 7'h7F, 1'b1, 1'b1);
        read_check("R10");
        check(rdata[31:24] === 8'hF9, "R10", {24'd0, rdata[31:24]}, 32'hF9);

        // R11: function-level reset clears bus-master enable, keeps flags
        cycle(1'b1, 32'h0000_0004, 4'h1, 7'h54, 1'b0, 1'b1);
        @(negedge clk); flr_rst_n = 1'b0;
        @(negedge clk); flr_rst_n = 1'b1;
        m_bme = 1'b0;
        read_check("R11");
        check(rdata[2] === 1'b0 && rdata[31:24] === 8'hF9, "R11", rdata, expect_word());

        // R1: power-on reset clears flags again
        @(negedge clk); por_rst_n = 1'b0;
        @(negedge clk); por_rst_n = 1'b1;
        m_st = '0; m_bme = 1'b0;
        read_check("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule